// File: doc/BRIEF.md
# Hypervisor Control Register Bank

This block stores the hypervisor-level control and status registers of a core and serves the core's register-access requests to them. Each request carries a 12-bit register address, an operation code, write data and a bit mask. The bank decides within the same cycle whether the request is allowed. An allowed request returns the register's current contents on the read-data output, and any update takes effect at the next rising clock edge. A refused request raises an illegal flag and changes nothing.

Seven of the registers are plain storage of the full register width. The pending and enable views of the virtual-supervisor interrupts are different. They have no storage of their own. Instead they are masked windows onto the machine interrupt-pending and interrupt-enable words, which this bank holds and drives out to the rest of the core. The machine side of the core can overwrite either shared word through a dedicated update port.

Every operation is carried out as a masked merge. A write uses an all-ones mask, a read uses an all-zero mask, and a read-modify-write uses the caller's mask. The pending window accepts only this merge path, with its mask cut down to the three virtual-supervisor bits.

Top module: `hvcsr_bank`

## Requirements
- R1: Any request (operation code not 0) is flagged illegal unless both the supervisor-present and hypervisor-present inputs are 1.
- R2: A request is legal only at privilege 3 (machine), or at privilege 1 (supervisor) with the virtualization flag at 0. Privilege 0, privilege 2, and privilege 1 with virtualization set are all illegal.
- R3: The mapped addresses are 0x600, 0x602, 0x603, 0x604, 0x606, 0x643, 0x644, 0x64A and 0x680. Any other address is illegal. Operation code 0 (idle) is never illegal and returns read data 0.
- R4: The registers at 0x600, 0x602, 0x603, 0x606, 0x643, 0x64A and 0x680 each read back the full-width value last written to them.
- R5: Operation codes are 1 = read, 2 = write and 3 = read-modify-write. A read-modify-write returns the old value and, on the same clock edge, stores (old AND NOT mask) OR (data AND mask).
- R6: Accesses at 0x644 act on the machine pending word. Only bits 2, 6 and 10 can change, and a read returns the whole pending word.
- R7: A read at 0x604 returns the machine enable word ANDed with the mask of bits 2, 6 and 10.
- R8: Writes at 0x604 change only bits 2, 6 and 10 of the machine enable word. All its other bits keep their values.
- R9: After reset, every register, the pending word and the enable word are zero.
- R10: An illegal request returns read data 0 and changes no register.
- R11: The machine update port replaces the whole pending word (select 0) or the whole enable word (select 1). It takes precedence over a hypervisor access to the same word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | 0 idle, 1 read, 2 write, 3 read-modify-write |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Bit mask used by read-modify-write |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| virt_on | input | 1 | Virtualization active |
| has_s | input | 1 | Supervisor extension present |
| has_h | input | 1 | Hypervisor extension present |
| mach_wr_en | input | 1 | Machine-side update of a shared interrupt word |
| mach_wr_mie | input | 1 | Update target: 0 pending word, 1 enable word |
| mach_wr_data | input | XLEN | Machine-side update value |
| csr_rdata | output | XLEN | Read data (old value), combinational |
| csr_illegal | output | 1 | Request refused, combinational |
| mip_o | output | XLEN | Machine interrupt-pending word |
| mie_o | output | XLEN | Machine interrupt-enable word |

## Verification
Most faults in this bank would show up as a wrong bit outside the three virtual-supervisor positions of the shared interrupt words. Such a bit appears on the exported pending or enable word at the clock edge after the faulty access, well before any later read could reveal it. A fault in the gate or the decode shows at once, because the illegal flag and read data are combinational. A corrupted plain register stays hidden until it is read back. For that reason the tests always read a register back right after each write or merge, and recheck registers after refused requests.

// File: rtl/hvcsr_pkg.sv
// Package: shared encodings for the hypervisor register bank.
// Assumes a 12-bit register address and a 2-bit privilege code.
package hvcsr_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RMW   = 2'b11
    } csr_op_e;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    // Slot numbering: plain registers first, then the two interrupt windows
    localparam int NUM_PLAIN = 7;
    localparam int SLOT_HIE  = NUM_PLAIN;
    localparam int SLOT_HIP  = NUM_PLAIN + 1;
    localparam int NUM_SLOTS = NUM_PLAIN + 2;

    // Positions of the virtual-supervisor interrupt bits in pending/enable words
    localparam int VS_SOFT_BIT = 2;
    localparam int VS_TIME_BIT = 6;
    localparam int VS_EXT_BIT  = 10;

    // Address of each slot
    function automatic logic [11:0] slot_addr(input int s);
        case (s)
            0:       return 12'h600;   // status
            1:       return 12'h602;   // exception delegation
            2:       return 12'h603;   // interrupt delegation
            3:       return 12'h606;   // counter enable
            4:       return 12'h643;   // trap value
            5:       return 12'h64A;   // trap instruction
            6:       return 12'h680;   // guest translation root
            7:       return 12'h604;   // interrupt enable window
            8:       return 12'h644;   // interrupt pending window
            default: return 12'h000;
        endcase
    endfunction

endpackage

// File: rtl/hvcsr_gate.sv
// Access gate and address decode.
// Produces a one-hot slot select that is nonzero only for a legal, active
// request; assumes extension straps and privilege are stable for the cycle.
module hvcsr_gate
    import hvcsr_pkg::*;
(
    input  logic [11:0]          addr,
    input  csr_op_e              op,
    input  logic [1:0]           priv,
    input  logic                 virt_on,
    input  logic                 has_s,
    input  logic                 has_h,
    output logic                 illegal,
    output logic [NUM_SLOTS-1:0] sel
);

    logic [NUM_SLOTS-1:0] match;
    logic                 ctx_ok;
    logic                 active;

    // One comparator per mapped slot
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
        assign match[s] = (addr == slot_addr(s));
    end

    // Privilege / extension check and final select
    always_comb begin
        ctx_ok  = has_s && has_h &&
                  ((priv == PRIV_M) || ((priv == PRIV_S) && !virt_on));
        active  = (op != OP_NONE);
        illegal = active && !(ctx_ok && (|match));
        sel     = (active && !illegal) ? match : '0;
    end

endmodule

// File: rtl/hvcsr_plain_bank.sv
// Plain full-width registers updated by masked merge.
// Assumes sel is one-hot or zero; the effective mask encodes the operation.
module hvcsr_plain_bank #(
    parameter int XLEN    = 64,
    parameter int NUM_REG = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REG-1:0] sel,
    input  logic [XLEN-1:0]    wdata,
    input  logic [XLEN-1:0]    wmask,
    output logic [XLEN-1:0]    rdata
);

    logic [XLEN-1:0] regs [NUM_REG];

    // One storage register per slot
    for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (sel[i])
                regs[i] <= (regs[i] & ~wmask) | (wdata & wmask);
        end
    end

    // OR-mux of the selected old value
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REG; i++)
            if (sel[i]) rdata = rdata | regs[i];
    end

endmodule

// File: rtl/hvcsr_irq_alias.sv
// Owner of the machine pending and enable words, with the hypervisor
// windows onto their virtual-supervisor bits. Machine updates win over a
// same-cycle window access.
module hvcsr_irq_alias
    import hvcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_hie,
    input  logic            sel_hip,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic            mach_we,
    input  logic            mach_mie,
    input  logic [XLEN-1:0] mach_data,
    output logic [XLEN-1:0] mip,
    output logic [XLEN-1:0] mie,
    output logic [XLEN-1:0] rdata
);

    localparam logic [XLEN-1:0] VS_MASK = (XLEN'(1) << VS_SOFT_BIT) |
                                          (XLEN'(1) << VS_TIME_BIT) |
                                          (XLEN'(1) << VS_EXT_BIT);

    logic [XLEN-1:0] vs_mask;

    // Restrict the effective mask to the window bits
    assign vs_mask = wmask & VS_MASK;

    // Pending word update
    always_ff @(posedge clk) begin
        if (!rst_n)
            mip <= '0;
        else if (mach_we && !mach_mie)
            mip <= mach_data;
        else if (sel_hip)
            mip <= (mip & ~vs_mask) | (wdata & vs_mask);
    end

    // Enable word update
    always_ff @(posedge clk) begin
        if (!rst_n)
            mie <= '0;
        else if (mach_we && mach_mie)
            mie <= mach_data;
        else if (sel_hie)
            mie <= (mie & ~vs_mask) | (wdata & vs_mask);
    end

    // Window read data
    always_comb begin
        if (sel_hie)      rdata = mie & VS_MASK;
        else if (sel_hip) rdata = mip;
        else              rdata = '0;
    end

endmodule

// File: rtl/hvcsr_bank.sv
// Top: hypervisor register bank. Read data and illegal flag are
// combinational; updates land on the next rising edge.
module hvcsr_bank
    import hvcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [1:0]      csr_op,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic [XLEN-1:0] csr_wmask,
    input  logic [1:0]      priv,
    input  logic            virt_on,
    input  logic            has_s,
    input  logic            has_h,
    input  logic            mach_wr_en,
    input  logic            mach_wr_mie,
    input  logic [XLEN-1:0] mach_wr_data,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output logic [XLEN-1:0] mip_o,
    output logic [XLEN-1:0] mie_o
);

    csr_op_e              op;
    logic [NUM_SLOTS-1:0] sel;
    logic [XLEN-1:0]      eff_mask;
    logic [XLEN-1:0]      plain_rd;
    logic [XLEN-1:0]      irq_rd;

    // Every operation becomes a masked merge
    always_comb begin
        op = csr_op_e'(csr_op);
        case (op)
            OP_WRITE: eff_mask = '1;
            OP_RMW:   eff_mask = csr_wmask;
            default:  eff_mask = '0;
        endcase
    end

    hvcsr_gate u_gate (
        .addr    (csr_addr),
        .op      (op),
        .priv    (priv),
        .virt_on (virt_on),
        .has_s   (has_s),
        .has_h   (has_h),
        .illegal (csr_illegal),
        .sel     (sel)
    );

    hvcsr_plain_bank #(.XLEN(XLEN), .NUM_REG(NUM_PLAIN)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel[NUM_PLAIN-1:0]),
        .wdata (csr_wdata),
        .wmask (eff_mask),
        .rdata (plain_rd)
    );

    hvcsr_irq_alias #(.XLEN(XLEN)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_hie   (sel[SLOT_HIE]),
        .sel_hip   (sel[SLOT_HIP]),
        .wdata     (csr_wdata),
        .wmask     (eff_mask),
        .mach_we   (mach_wr_en),
        .mach_mie  (mach_wr_mie),
        .mach_data (mach_wr_data),
        .mip       (mip_o),
        .mie       (mie_o),
        .rdata     (irq_rd)
    );

    // Combine read paths (each is zero when unselected)
    assign csr_rdata = plain_rd | irq_rd;

endmodule

// File: rtl/hvcsr_bank_chk.sv
// Checker for hvcsr_bank, attached by bind. Observes ports only.
module hvcsr_bank_chk
    import hvcsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [11:0]     csr_addr,
    input logic [1:0]      csr_op,
    input logic [1:0]      priv,
    input logic            virt_on,
    input logic            has_s,
    input logic            has_h,
    input logic            mach_wr_en,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic [XLEN-1:0] mip_o,
    input logic [XLEN-1:0] mie_o
);

    localparam logic [XLEN-1:0] VS = (XLEN'(1) << VS_SOFT_BIT) |
                                     (XLEN'(1) << VS_TIME_BIT) |
                                     (XLEN'(1) << VS_EXT_BIT);

    a_r1_ext_missing: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op != 2'b00 && !(has_s && has_h)) |-> csr_illegal);

    a_r2_guest_or_user: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op != 2'b00 && (priv == PRIV_U || priv == 2'd2 ||
                             (priv == PRIV_S && virt_on))) |-> csr_illegal);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op == 2'b00) |-> (!csr_illegal && csr_rdata == '0));

    a_r7_enable_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_op != 2'b00 && csr_addr == 12'h604 && !csr_illegal)
            |-> ((csr_rdata & ~VS) == '0));

    a_r8_enable_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !mach_wr_en |=> ((mie_o & ~VS) == ($past(mie_o) & ~VS)));

    a_r6_pending_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !mach_wr_en |=> ((mip_o & ~VS) == ($past(mip_o) & ~VS)));

    a_r10_illegal_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_illegal && !mach_wr_en) |=> ($stable(mip_o) && $stable(mie_o)));

    a_r10_illegal_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

endmodule

bind hvcsr_bank hvcsr_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_op      (csr_op),
    .priv        (priv),
    .virt_on     (virt_on),
    .has_s       (has_s),
    .has_h       (has_h),
    .mach_wr_en  (mach_wr_en),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .mip_o       (mip_o),
    .mie_o       (mie_o)
);

// File: tb/hvcsr_bank_tb.sv
// Directed bench for hvcsr_bank: one task per scenario.
module hvcsr_bank_tb;

    localparam int XLEN = 64;
    localparam logic [63:0] VS   = 64'h444;
    localparam logic [63:0] ONES = '1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [1:0]      csr_op = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_wmask = '0;
    logic [1:0]      priv = 2'd3;
    logic            virt_on = 1'b0;
    logic            has_s = 1'b1;
    logic            has_h = 1'b1;
    logic            mach_wr_en = 1'b0;
    logic            mach_wr_mie = 1'b0;
    logic [XLEN-1:0] mach_wr_data = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic [XLEN-1:0] mip_o;
    logic [XLEN-1:0] mie_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    hvcsr_bank #(.XLEN(XLEN)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One request; samples combinational outputs before the update edge
    task automatic acc(input logic [11:0] a, input logic [1:0] op, input logic [63:0] wd,
                       input logic [63:0] wm, output logic [63:0] rd, output logic ill);
        @(negedge clk);
        csr_addr = a; csr_op = op; csr_wdata = wd; csr_wmask = wm;
        #1;
        rd = csr_rdata; ill = csr_illegal;
        @(posedge clk); #1;
        csr_op = 2'b00; mach_wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [63:0] exp, input string tag);
        logic [63:0] rd; logic ill;
        acc(a, 2'b01, '0, '0, rd, ill);
        chk(!ill && rd == exp, tag, rd, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        logic [63:0] rd; logic ill;
        acc(a, 2'b10, d, '0, rd, ill);
    endtask

    task automatic mach(input bit to_mie, input logic [63:0] d);
        @(negedge clk);
        mach_wr_en = 1'b1; mach_wr_mie = to_mie; mach_wr_data = d;
        @(posedge clk); #1;
        mach_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [11:0] addrs [7] = '{12'h600, 12'h602, 12'h603, 12'h606, 12'h643, 12'h64A, 12'h680};
        chk(mip_o == '0, "R9 pending word reset", mip_o, 0);
        chk(mie_o == '0, "R9 enable word reset", mie_o, 0);
        chk(!csr_illegal && csr_rdata == '0, "R3 idle quiet", csr_rdata, 0);
        foreach (addrs[i]) rd_expect(addrs[i], '0, "R9 register reset");
    endtask

    task automatic t_plain();
        logic [11:0] addrs [7] = '{12'h600, 12'h602, 12'h603, 12'h606, 12'h643, 12'h64A, 12'h680};
        foreach (addrs[i]) wr(addrs[i], 64'hA5C3_0000_0000_0000 | (64'h1111 * (i + 1)) | 64'h8000_0000_0000_0001);
        foreach (addrs[i]) rd_expect(addrs[i], 64'hA5C3_0000_0000_0000 | (64'h1111 * (i + 1)) | 64'h8000_0000_0000_0001,
                                     "R4 plain readback");
    endtask

    task automatic t_rmw();
        logic [63:0] rd; logic ill;
        wr(12'h680, 64'hFFFF_0000_FFFF_0000);
        acc(12'h680, 2'b11, 64'h1234_5678_9ABC_DEF0, 64'h00FF_00FF_00FF_00FF, rd, ill);
        chk(!ill && rd == 64'hFFFF_0000_FFFF_0000, "R5 rmw returns old", rd, 64'hFFFF_0000_FFFF_0000);
        rd_expect(12'h680, 64'hFF34_0078_FFBC_00F0, "R5 rmw merged value");
    endtask

    task automatic t_unmapped();
        logic [63:0] rd; logic ill;
        acc(12'h601, 2'b01, '0, '0, rd, ill);
        chk(ill && rd == '0, "R3 unmapped 0x601", {63'd0, ill}, 1);
        acc(12'h645, 2'b10, ONES, '0, rd, ill);
        chk(ill, "R3 unmapped 0x645", {63'd0, ill}, 1);
        acc(12'h300, 2'b01, '0, '0, rd, ill);
        chk(ill, "R3 address outside range", {63'd0, ill}, 1);
    endtask

    task automatic t_ext();
        logic [63:0] rd; logic ill;
        wr(12'h600, 64'h55);
        has_h = 1'b0;
        acc(12'h600, 2'b10, 64'hAA, '0, rd, ill);
        chk(ill, "R1 hypervisor strap off", {63'd0, ill}, 1);
        has_h = 1'b1; has_s = 1'b0;
        acc(12'h600, 2'b01, '0, '0, rd, ill);
        chk(ill && rd == '0, "R1 supervisor strap off", rd, 0);
        has_s = 1'b1;
        rd_expect(12'h600, 64'h55, "R10 illegal write left register");
    endtask

    task automatic t_priv();
        logic [63:0] rd; logic ill;
        priv = 2'd0;
        acc(12'h602, 2'b01, '0, '0, rd, ill);
        chk(ill, "R2 user illegal", {63'd0, ill}, 1);
        priv = 2'd2;
        acc(12'h602, 2'b01, '0, '0, rd, ill);
        chk(ill, "R2 reserved level illegal", {63'd0, ill}, 1);
        priv = 2'd1; virt_on = 1'b1;
        acc(12'h602, 2'b10, 64'h9, '0, rd, ill);
        chk(ill, "R2 virtual supervisor illegal", {63'd0, ill}, 1);
        virt_on = 1'b0;
        acc(12'h602, 2'b10, 64'h7, '0, rd, ill);
        chk(!ill, "R2 supervisor legal", {63'd0, ill}, 0);
        priv = 2'd3; virt_on = 1'b1;
        rd_expect(12'h602, 64'h7, "R2 machine with virt legal");
        virt_on = 1'b0;
    endtask

    task automatic t_pending();
        logic [63:0] rd; logic ill;
        mach(1'b0, ONES);
        chk(mip_o == ONES, "R11 machine writes pending", mip_o, ONES);
        rd_expect(12'h644, ONES, "R6 pending read is whole word");
        wr(12'h644, '0);
        chk(mip_o == ~VS, "R6 write clears only window bits", mip_o, ~VS);
        acc(12'h644, 2'b11, ONES, 64'h40, rd, ill);
        chk(rd == ~VS, "R6 rmw returns old pending", rd, ~VS);
        chk(mip_o == (~VS | 64'h40), "R6 rmw sets bit 6 only", mip_o, ~VS | 64'h40);
        mach(1'b0, '0);
        wr(12'h644, ONES);
        chk(mip_o == VS, "R6 write of ones sets window bits only", mip_o, VS);
    endtask

    task automatic t_enable();
        logic [63:0] rd; logic ill;
        mach(1'b1, ONES);
        rd_expect(12'h604, VS, "R7 enable read masked");
        wr(12'h604, '0);
        chk(mie_o == ~VS, "R8 write keeps other enable bits", mie_o, ~VS);
        rd_expect(12'h604, '0, "R7 enable read after clear");
        priv = 2'd0;
        acc(12'h604, 2'b10, ONES, '0, rd, ill);
        priv = 2'd3;
        chk(ill && mie_o == ~VS, "R10 illegal enable write ignored", mie_o, ~VS);
        // R11: machine update and window write in the same cycle
        @(negedge clk);
        mach_wr_en = 1'b1; mach_wr_mie = 1'b1; mach_wr_data = 64'h0F0F_0000_0000_0000;
        acc(12'h604, 2'b10, ONES, '0, rd, ill);
        chk(mie_o == 64'h0F0F_0000_0000_0000, "R11 machine update wins", mie_o, 64'h0F0F_0000_0000_0000);
    endtask

    initial begin : watchdog
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_plain();
        t_rmw();
        t_unmapped();
        t_ext();
        t_priv();
        t_pending();
        t_enable();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule